// File: doc/BRIEF.md
# Accumulator ADD Core

A small multi-cycle 8-bit processor built around an accumulator. It holds five registers: accumulator, data, program counter, instruction and flags. It runs a program stored in an internal eight-byte memory. Every instruction begins with a fetch cycle that copies the byte at the program counter into the instruction register. An execute step follows, which adds a register, immediate or memory-direct operand to the accumulator. The same step updates the zero and sign flags and moves the program counter past the instruction. Any byte that is not one of the three add opcodes does nothing and takes one byte.

The memory is filled through a preload port, normally while reset is held. The sequencer and all registers freeze for as long as the port is in use. Every register is brought out on a read-only debug output, so a program's progress can be followed cycle by cycle.

Top module: `acc_core`

## Requirements
- R1: While reset is asserted and right after it is released, the debug outputs read accumulator 0x06, data 0x02, program counter 0x00, instruction 0x00 and flags 0x00.
- R2: Every instruction starts with a fetch cycle that loads the instruction register from memory at the program counter and leaves accumulator, flags and program counter unchanged. Opcodes 0x1A, 0x1B and undefined opcodes complete on the second clock edge. Opcode 0x1C completes on the third.
- R3: Opcode 0x1A adds the data register to the accumulator modulo 256 and advances the program counter by 1.
- R4: Opcode 0x1B adds the byte at program counter + 1 to the accumulator modulo 256 and advances the program counter by 2.
- R5: Opcode 0x1C reads the byte at program counter + 1 and uses its low three bits as an address. It adds the byte at that address to the accumulator and advances the program counter by 2.
- R6: After each add, flags bit 0 is 1 exactly when the new accumulator is zero, and flags bit 1 equals bit 7 of the new accumulator. Flags bits 7..2 keep their value of 0.
- R7: Any opcode other than 0x1A, 0x1B, 0x1C leaves accumulator and flags unchanged and advances the program counter by 1.
- R8: The program counter counts modulo 8 and its upper five output bits are always 0. Program counter + 1 wraps from 7 to 0.
- R9: On each clock edge where ld_en_i is high, ld_data_i is written to the memory byte at ld_addr_i, and the sequencer and all registers hold. Reset does not clear the memory, and writes are accepted during reset.
- R10: The data register never changes after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_en_i | input | 1 | Memory preload write enable; stalls the core |
| ld_addr_i | input | 3 | Preload byte address |
| ld_data_i | input | 8 | Preload byte value |
| acc_o | output | 8 | Accumulator |
| dat_o | output | 8 | Data register |
| pc_o | output | 8 | Program counter, zero-extended |
| ir_o | output | 8 | Instruction register |
| flg_o | output | 8 | Flags: bit 0 zero, bit 1 sign |

## Verification
The flag invariant assumes the reset values of accumulator and flags agree with each other, which holds for the default parameters (accumulator 0x06, flags 0x00). The stall and program-counter properties assume that ld_en_i is only sampled at clock edges and never changes between them. The stimulus therefore drives every input at the falling edge, leaves all parameters at their defaults, and preloads memory while reset is held. The one deliberate exception is a test that asserts ld_en_i in the middle of an instruction.

// File: rtl/acc_core_pkg.sv
`timescale 1ns/1ps
package acc_core_pkg;
  localparam logic [7:0] OPC_ADD_REG = 8'h1A;
  localparam logic [7:0] OPC_ADD_IMM = 8'h1B;
  localparam logic [7:0] OPC_ADD_MEM = 8'h1C;

  localparam int unsigned FLG_Z_BIT = 0;
  localparam int unsigned FLG_S_BIT = 1;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_PTR   = 2'd1,
    ST_EXEC  = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_REG  = 2'd0,
    OP_IMM  = 2'd1,
    OP_MEM  = 2'd2,
    OP_NONE = 2'd3
  } op_kind_e;
endpackage

// File: rtl/acc_mem.sv
`timescale 1ns/1ps
module acc_mem #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 3
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] ra_addr_i,
  output logic [DW-1:0] ra_data_o,
  input  logic [AW-1:0] rb_addr_i,
  output logic [DW-1:0] rb_data_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  // no reset: contents survive rst_ni
  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign ra_data_o = mem_q[ra_addr_i];
  assign rb_data_o = mem_q[rb_addr_i];
endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] sum_o,
  output logic          zero_o,
  output logic          neg_o
);
  assign sum_o  = a_i + b_i;
  assign zero_o = (sum_o == '0);
  assign neg_o  = sum_o[DW-1];
endmodule

// File: rtl/acc_ctrl.sv
`timescale 1ns/1ps
module acc_ctrl
  import acc_core_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  input  logic [DW-1:0] ra_data_i,
  input  logic [DW-1:0] rb_data_i,
  input  logic [DW-1:0] d_i,
  output logic [AW-1:0] ra_addr_o,
  output logic [AW-1:0] rb_addr_o,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] ir_o,
  output logic [DW-1:0] opnd_o,
  output logic          acc_we_o,
  output logic          in_fetch_o,
  output logic          in_exec_o
);
  seq_state_e    st_q;
  logic [AW-1:0] pc_q, ptr_q, step;
  logic [DW-1:0] ir_q;
  op_kind_e      kind, fetch_kind;

  function automatic op_kind_e classify(input logic [DW-1:0] b);
    if      (b == DW'(OPC_ADD_REG)) return OP_REG;
    else if (b == DW'(OPC_ADD_IMM)) return OP_IMM;
    else if (b == DW'(OPC_ADD_MEM)) return OP_MEM;
    else                            return OP_NONE;
  endfunction

  assign kind       = classify(ir_q);
  assign fetch_kind = classify(ra_data_i);
  assign step       = (kind == OP_IMM || kind == OP_MEM) ? AW'(2) : AW'(1);

  assign ra_addr_o = pc_q;
  // operand port: pointer target in memory-direct execute, else byte after opcode
  assign rb_addr_o = (st_q == ST_EXEC && kind == OP_MEM) ? ptr_q : pc_q + AW'(1);

  always_comb begin
    unique case (kind)
      OP_REG:         opnd_o = d_i;
      OP_IMM, OP_MEM: opnd_o = rb_data_i;
      default:        opnd_o = '0;
    endcase
  end

  assign acc_we_o   = (st_q == ST_EXEC) && (kind != OP_NONE) && !hold_i;
  assign in_fetch_o = (st_q == ST_FETCH);
  assign in_exec_o  = (st_q == ST_EXEC);
  assign pc_o       = pc_q;
  assign ir_o       = ir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_FETCH;
      pc_q  <= '0;
      ptr_q <= '0;
      ir_q  <= '0;
    end else if (!hold_i) begin
      unique case (st_q)
        ST_FETCH: begin
          ir_q <= ra_data_i;
          st_q <= (fetch_kind == OP_MEM) ? ST_PTR : ST_EXEC;
        end
        ST_PTR: begin
          ptr_q <= rb_data_i[AW-1:0];
          st_q  <= ST_EXEC;
        end
        ST_EXEC: begin
          pc_q <= pc_q + step;
          st_q <= ST_FETCH;
        end
        default: st_q <= ST_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/acc_core.sv
`timescale 1ns/1ps
module acc_core
  import acc_core_pkg::*;
#(
  parameter int unsigned   DW    = 8,
  parameter int unsigned   AW    = 3,
  parameter logic [DW-1:0] A_RST = 8'h06,
  parameter logic [DW-1:0] D_RST = 8'h02,
  parameter logic [DW-1:0] F_RST = 8'h00
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_en_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [DW-1:0] ld_data_i,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] dat_o,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] ir_o,
  output logic [DW-1:0] flg_o
);
  localparam int unsigned PAD_W = DW - AW;

  logic [AW-1:0] ra_addr, rb_addr, pc;
  logic [DW-1:0] ra_data, rb_data, opnd, sum;
  logic [DW-1:0] acc_q, dat_q, flg_q, flg_d;
  logic          acc_we, zero, neg;
  logic          in_fetch, in_exec;

  acc_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk_i     (clk_i),
    .wr_en_i   (ld_en_i),
    .wr_addr_i (ld_addr_i),
    .wr_data_i (ld_data_i),
    .ra_addr_i (ra_addr),
    .ra_data_o (ra_data),
    .rb_addr_i (rb_addr),
    .rb_data_o (rb_data)
  );

  acc_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_i     (ld_en_i),
    .ra_data_i  (ra_data),
    .rb_data_i  (rb_data),
    .d_i        (dat_q),
    .ra_addr_o  (ra_addr),
    .rb_addr_o  (rb_addr),
    .pc_o       (pc),
    .ir_o       (ir_o),
    .opnd_o     (opnd),
    .acc_we_o   (acc_we),
    .in_fetch_o (in_fetch),
    .in_exec_o  (in_exec)
  );

  acc_alu #(.DW(DW)) u_alu (
    .a_i    (acc_q),
    .b_i    (opnd),
    .sum_o  (sum),
    .zero_o (zero),
    .neg_o  (neg)
  );

  always_comb begin
    flg_d            = flg_q;
    flg_d[FLG_Z_BIT] = zero;
    flg_d[FLG_S_BIT] = neg;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= A_RST;
      flg_q <= F_RST;
    end else if (acc_we) begin
      acc_q <= sum;
      flg_q <= flg_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dat_q <= D_RST;
    else         dat_q <= dat_q;
  end

  assign acc_o = acc_q;
  assign dat_o = dat_q;
  assign flg_o = flg_q;
  assign pc_o  = {{PAD_W{1'b0}}, pc};
endmodule

// File: rtl/acc_core_chk.sv
`timescale 1ns/1ps
module acc_core_chk
  import acc_core_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ld_en_i,
  input logic [DW-1:0] acc_o,
  input logic [DW-1:0] dat_o,
  input logic [DW-1:0] pc_o,
  input logic [DW-1:0] ir_o,
  input logic [DW-1:0] flg_o,
  input logic          in_fetch,
  input logic          in_exec
);
  logic ir_valid;
  assign ir_valid = (ir_o == DW'(OPC_ADD_REG)) || (ir_o == DW'(OPC_ADD_IMM)) ||
                    (ir_o == DW'(OPC_ADD_MEM));

  p_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_en_i |=> $stable(acc_o) && $stable(pc_o) && $stable(ir_o) && $stable(flg_o));

  p_flags_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flg_o[FLG_Z_BIT] == (acc_o == '0)) && (flg_o[FLG_S_BIT] == acc_o[DW-1]) &&
    (flg_o[DW-1:2] == '0));

  p_fetch_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_fetch && !ld_en_i) |=> $stable(acc_o) && $stable(pc_o) && $stable(flg_o));

  p_pc_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_exec && !ld_en_i) |=>
      (pc_o[AW-1:0] == AW'($past(pc_o[AW-1:0]) +
        ((($past(ir_o) == DW'(OPC_ADD_IMM)) || ($past(ir_o) == DW'(OPC_ADD_MEM))) ? 2 : 1)))
      && (pc_o[DW-1:AW] == '0));

  p_nop_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_exec && !ld_en_i && !ir_valid) |=> $stable(acc_o) && $stable(flg_o));

  p_dat_const_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(dat_o));
endmodule

bind acc_core acc_core_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ld_en_i  (ld_en_i),
  .acc_o    (acc_o),
  .dat_o    (dat_o),
  .pc_o     (pc_o),
  .ir_o     (ir_o),
  .flg_o    (flg_o),
  .in_fetch (in_fetch),
  .in_exec  (in_exec)
);

// File: tb/acc_core_tb.sv
`timescale 1ns/1ps
module acc_core_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ld_en_i = 1'b0;
  logic [2:0] ld_addr_i = '0;
  logic [7:0] ld_data_i = '0;
  logic [7:0] acc_o, dat_o, pc_o, ir_o, flg_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] prog [8];

  always #2.5 clk_i = ~clk_i;

  acc_core u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_en_i   (ld_en_i),
    .ld_addr_i (ld_addr_i),
    .ld_data_i (ld_data_i),
    .acc_o     (acc_o),
    .dat_o     (dat_o),
    .pc_o      (pc_o),
    .ir_o      (ir_o),
    .flg_o     (flg_o)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%02h exp=%02h", req, what, act, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  // preload under reset, then release
  task automatic load_prog();
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int i = 0; i < 8; i++) begin
      ld_en_i = 1'b1; ld_addr_i = 3'(i); ld_data_i = prog[i];
      @(negedge clk_i);
    end
    ld_en_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    prog = '{8'h1A, 8'h1B, 8'h03, 8'h1C, 8'h07, 8'h00, 8'h00, 8'h42};
    load_prog();
    chk("R1", "acc", acc_o, 8'h06);
    chk("R1", "dat", dat_o, 8'h02);
    chk("R1", "pc",  pc_o,  8'h00);
    chk("R1", "ir",  ir_o,  8'h00);
    chk("R1", "flg", flg_o, 8'h00);
  endtask

  task automatic t_demo();
    prog = '{8'h1A, 8'h1B, 8'h03, 8'h1C, 8'h07, 8'h00, 8'h00, 8'h42};
    load_prog();
    run(1);
    chk("R2", "fetch ir", ir_o, 8'h1A);
    chk("R2", "fetch acc held", acc_o, 8'h06);
    chk("R2", "fetch pc held", pc_o, 8'h00);
    run(1);
    chk("R3", "acc", acc_o, 8'h08);
    chk("R3", "pc", pc_o, 8'h01);
    chk("R6", "flg", flg_o, 8'h00);
    run(2);
    chk("R4", "acc", acc_o, 8'h0B);
    chk("R4", "pc", pc_o, 8'h03);
    run(2);
    chk("R2", "mem op mid acc", acc_o, 8'h0B);
    chk("R2", "mem op mid pc", pc_o, 8'h03);
    chk("R2", "mem op ir", ir_o, 8'h1C);
    run(1);
    chk("R5", "acc", acc_o, 8'h4D);
    chk("R5", "pc", pc_o, 8'h05);
    chk("R6", "flg", flg_o, 8'h00);
    run(2);
    chk("R7", "nop acc", acc_o, 8'h4D);
    chk("R7", "nop pc", pc_o, 8'h06);
    chk("R10", "dat", dat_o, 8'h02);
  endtask

  task automatic t_flags();
    prog = '{8'h1B, 8'hFA, 8'h1B, 8'h80, 8'h55, 8'h00, 8'h00, 8'h00};
    load_prog();
    run(2);
    chk("R6", "zero acc", acc_o, 8'h00);
    chk("R6", "zero flg", flg_o, 8'h01);
    run(2);
    chk("R6", "neg acc", acc_o, 8'h80);
    chk("R6", "neg flg", flg_o, 8'h02);
    run(2);
    chk("R7", "bad op ir", ir_o, 8'h55);
    chk("R7", "bad op acc", acc_o, 8'h80);
    chk("R7", "bad op flg", flg_o, 8'h02);
    chk("R7", "bad op pc", pc_o, 8'h05);
  endtask

  task automatic t_nop_keeps_zero();
    prog = '{8'h1B, 8'hFA, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    load_prog();
    run(4);
    chk("R7", "acc", acc_o, 8'h00);
    chk("R7", "flg z kept", flg_o, 8'h01);
    chk("R7", "pc", pc_o, 8'h03);
  endtask

  task automatic t_wrap_imm();
    prog = '{8'h05, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h1B};
    load_prog();
    run(16);
    chk("R8", "imm from addr 0 acc", acc_o, 8'h0B);
    chk("R8", "pc wrapped", pc_o, 8'h01);
    chk("R8", "flg", flg_o, 8'h00);
  endtask

  task automatic t_ptr_wrap();
    prog = '{8'h1C, 8'hF9, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    load_prog();
    run(3);
    chk("R5", "ptr low bits acc", acc_o, 8'hFF);
    chk("R8", "pc", pc_o, 8'h02);
    chk("R6", "sign flg", flg_o, 8'h02);
  endtask

  task automatic t_stall();
    prog = '{8'h1A, 8'h1B, 8'h03, 8'h1C, 8'h07, 8'h00, 8'h00, 8'h42};
    load_prog();
    run(1);
    ld_en_i = 1'b1; ld_addr_i = 3'd2; ld_data_i = 8'h10;
    run(3);
    ld_en_i = 1'b0;
    chk("R9", "stall acc", acc_o, 8'h06);
    chk("R9", "stall pc", pc_o, 8'h00);
    chk("R9", "stall ir", ir_o, 8'h1A);
    run(1);
    chk("R9", "resume acc", acc_o, 8'h08);
    run(2);
    chk("R9", "written imm acc", acc_o, 8'h18);
    chk("R9", "pc", pc_o, 8'h03);
    // reset alone keeps memory
    rst_ni = 1'b0;
    run(2);
    rst_ni = 1'b1;
    run(4);
    chk("R9", "memory kept acc", acc_o, 8'h18);
    chk("R10", "dat", dat_o, 8'h02);
  endtask

  initial begin
    t_reset();
    t_demo();
    t_flags();
    t_nop_keeps_zero();
    t_wrap_imm();
    t_ptr_wrap();
    t_stall();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule